// File: doc/BRIEF.md
# Dual-Clock FIFO with Occupancy Status

This block is a first-in first-out buffer that crosses data between two clock domains with no fixed phase or frequency relation. A producer on the write clock pushes words with a write enable. A consumer on the read clock pulls them with a read enable. Each side reports its own status, computed only from values that are valid in its own clock domain. Pointers are binary inside each domain and are exchanged as Gray code through two-stage synchronizers, so a pointer seen in the far domain is stale by a few cycles but never corrupt.

The write side reports full and almost full. It also reports a programmable-full flag with separate set and clear thresholds, a one-cycle-late acknowledge or overflow pulse for every write attempt, and an occupancy count. That count can only be pessimistic, because the read pointer it uses is stale. The read side reports empty, almost empty, a programmable-empty flag, a registered data-valid strobe with the data, an underflow pulse and a count of readable words. That count can only under-report. One synchronous reset input clears both domains. Each domain holds a busy flag while it is still in reset and refuses operations during that time.

Top module: `dual_clock_fifo`

## Requirements
- R1: A write attempted while wr_full is high stores nothing and leaves the stored words intact. wr_overflow is high in the next write-clock cycle and wr_ack is low.
- R2: A write attempted while wr_full is low is stored. wr_ack is high in the next write-clock cycle and wr_overflow is low.
- R3: A read attempted while rd_empty is high changes nothing. rd_underflow is high in the next read-clock cycle and rd_valid is low.
- R4: Words leave in the order they were accepted. After an accepted read, rd_valid is high in the next read-clock cycle and rd_data holds the oldest stored word.
- R5: Once both clocks have idled, wr_full is high exactly when DEPTH words are stored, and wr_almost_full is high exactly when DEPTH-1 words are stored.
- R6: Once both clocks have idled, rd_empty is high exactly when no word is stored, and rd_almost_empty is high exactly when one word is stored.
- R7: wr_prog_full sets when the write-side occupancy reaches PFULL_SET or more. It stays set until that occupancy drops below PFULL_CLR, where PFULL_CLR < PFULL_SET.
- R8: rd_prog_empty is high while the read-side occupancy is at most PEMPTY_TH, and low above it.
- R9: wr_level never under-reports the stored words and equals the stored count once both sides idle. An accepted write shows in wr_level on the second write-clock edge after it, not the first.
- R10: rd_level never over-reports the readable words. It equals the readable count once both sides idle. It keeps only the top RD_CNT_W bits of the (log2(DEPTH)+1)-bit occupancy, so it is occupancy >> (log2(DEPTH)+1-RD_CNT_W). An accepted read shows on the second read-clock edge after it.
- R11: While rst is high, and for two edges of its own clock after rst falls, each domain holds its busy flag high and accepts no operation. When the busy flags fall, the block is empty: both levels are 0, rd_empty and rd_prog_empty are 1, and the other flags are 0.
- R12: Each domain's Gray pointer changes by at most one bit per clock edge, so a synchronized pointer is always a real past value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous reset for both domains, sampled on each clock |
| wr_clk | input | 1 | Write-domain clock |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No free slot (write side view) |
| wr_almost_full | output | 1 | Exactly one free slot |
| wr_prog_full | output | 1 | Occupancy flag with set/clear hysteresis |
| wr_ack | output | 1 | Previous-cycle write was stored |
| wr_overflow | output | 1 | Previous-cycle write was refused because full |
| wr_level | output | WR_CNT_W | Pessimistic occupancy, upper bits kept |
| wr_rst_busy | output | 1 | Write domain still in reset |
| rd_clk | input | 1 | Read-domain clock |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Word returned by the last accepted read |
| rd_empty | output | 1 | Nothing readable (read side view) |
| rd_almost_empty | output | 1 | Exactly one readable word |
| rd_prog_empty | output | 1 | Occupancy at or below PEMPTY_TH |
| rd_valid | output | 1 | rd_data was loaded by the previous-cycle read |
| rd_underflow | output | 1 | Previous-cycle read was refused because empty |
| rd_level | output | RD_CNT_W | Conservative readable count, upper bits kept |
| rd_rst_busy | output | 1 | Read domain still in reset |

## Verification
The bench builds the block with 8-bit words, DEPTH=8 and a 4-bit wr_level, so the full count up to 8 is visible without truncation. It uses a 2-bit rd_level, which exercises truncation: that output reads 1 only at four through seven words and 2 only at eight. The thresholds are PFULL_SET=6, PFULL_CLR=3 and PEMPTY_TH=2. With these values a single fill and drain crosses every flag edge, and the drain passes through the hysteresis band at five, four and three words, where prog-full must hold. The small depth lets random traffic with a fast writer and a slow reader hit full and overflow often. The two clocks are run at unrelated periods so that the pointer crossings land at varying phases.

// File: rtl/afq_pkg.sv
package afq_pkg;

  // Binary to reflected Gray code.
  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Reflected Gray code back to binary: each bit is the parity of itself and all higher bits.
  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b = '0;
    for (int i = 0; i < 32; i++) begin
      b[i] = ^(g >> i);
    end
    return b;
  endfunction

  // Two-threshold hysteresis: set at or above set_at, clear below clr_below, else hold.
  function automatic logic hyst_next(input logic cur, input logic [31:0] lvl,
                                     input logic [31:0] set_at, input logic [31:0] clr_below);
    if (lvl >= set_at) return 1'b1;
    if (lvl < clr_below) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/afq_sync.sv
module afq_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk) begin
    if (clr) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/afq_ram.sv
module afq_ram #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int ENTRIES = 1 << AW;

  logic [DW-1:0] store [ENTRIES];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/afq_wr_ctl.sv
module afq_wr_ctl #(
  parameter int AW     = 4,
  parameter int CW     = 5,
  parameter int PF_SET = 12,
  parameter int PF_CLR = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW:0]   rd_gray_x,
  output logic [AW:0]   wr_gray,
  output logic [AW-1:0] wr_addr,
  output logic          wr_fire,
  output logic          full,
  output logic          almost_full,
  output logic          prog_full,
  output logic          ack,
  output logic          overflow,
  output logic [CW-1:0] level,
  output logic          busy
);
  localparam int PW = AW + 1;
  localparam logic [AW:0] LVL_FULL = PW'(1 << AW);
  localparam logic [AW:0] LVL_AF   = PW'((1 << AW) - 1);
  localparam logic [AW:0] LVL_CLR  = PW'(PF_CLR);

  logic [1:0]  rst_q;
  logic [AW:0] rd_gray_s, rd_bin_s;
  logic [AW:0] wr_bin, wr_bin_nxt;
  logic [AW:0] lvl_now, lvl_nxt;

  // Reset stretch: busy covers rst plus two local edges after it falls.
  always_ff @(posedge clk) rst_q <= {rst_q[0], rst};
  assign busy = rst | rst_q[0] | rst_q[1];

  afq_sync #(.W(PW)) u_rsync (
    .clk (clk),
    .clr (busy),
    .d   (rd_gray_x),
    .q   (rd_gray_s)
  );

  assign rd_bin_s   = PW'(afq_pkg::gray_to_bin(32'(rd_gray_s)));
  assign wr_fire    = wr_en & ~full & ~busy;
  assign wr_bin_nxt = wr_bin + PW'(wr_fire);
  assign lvl_now    = wr_bin - rd_bin_s;
  assign lvl_nxt    = wr_bin_nxt - rd_bin_s;
  assign wr_addr    = wr_bin[AW-1:0];

  always_ff @(posedge clk) begin
    if (busy) begin
      wr_bin      <= '0;
      wr_gray     <= '0;
      full        <= 1'b0;
      almost_full <= 1'b0;
      prog_full   <= 1'b0;
      ack         <= 1'b0;
      overflow    <= 1'b0;
      level       <= '0;
    end else begin
      wr_bin      <= wr_bin_nxt;
      wr_gray     <= PW'(afq_pkg::bin_to_gray(32'(wr_bin_nxt)));
      full        <= (lvl_nxt == LVL_FULL);
      almost_full <= (lvl_nxt == LVL_AF);
      prog_full   <= afq_pkg::hyst_next(prog_full, 32'(lvl_nxt), 32'(PF_SET), 32'(PF_CLR));
      ack         <= wr_fire;
      overflow    <= wr_en & full;
      level       <= CW'(lvl_now >> (PW - CW));
    end
  end

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (busy)
    (wr_en && full) |=> (overflow && !ack && $stable(wr_bin)));

  p_ack_r2: assert property (@(posedge clk) disable iff (busy)
    (wr_en && !full) |=> (ack && !overflow));

  p_full_af_excl_r5: assert property (@(posedge clk) disable iff (busy)
    !(full && almost_full));

  p_pf_hold_r7: assert property (@(posedge clk) disable iff (busy)
    (prog_full && lvl_nxt >= LVL_CLR) |=> prog_full);

  p_level_bound_r9: assert property (@(posedge clk) disable iff (busy)
    lvl_now <= LVL_FULL);

  p_gray_step_r12: assert property (@(posedge clk) disable iff (busy)
    $onehot0(wr_gray ^ $past(wr_gray)));
endmodule

// File: rtl/afq_rd_ctl.sv
module afq_rd_ctl #(
  parameter int DW    = 32,
  parameter int AW    = 4,
  parameter int CW    = 5,
  parameter int PE_TH = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW:0]   wr_gray_x,
  input  logic [DW-1:0] mem_q,
  output logic [AW:0]   rd_gray,
  output logic [AW-1:0] rd_addr,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          almost_empty,
  output logic          prog_empty,
  output logic          valid,
  output logic          underflow,
  output logic [CW-1:0] level,
  output logic          busy
);
  localparam int PW = AW + 1;
  localparam logic [AW:0] LVL_FULL = PW'(1 << AW);
  localparam logic [AW:0] LVL_ONE  = PW'(1);
  localparam logic [AW:0] LVL_PE   = PW'(PE_TH);

  logic [1:0]  rst_q;
  logic [AW:0] wr_gray_s, wr_bin_s;
  logic [AW:0] rd_bin, rd_bin_nxt;
  logic [AW:0] lvl_now, lvl_nxt;
  logic        rd_fire;

  always_ff @(posedge clk) rst_q <= {rst_q[0], rst};
  assign busy = rst | rst_q[0] | rst_q[1];

  afq_sync #(.W(PW)) u_wsync (
    .clk (clk),
    .clr (busy),
    .d   (wr_gray_x),
    .q   (wr_gray_s)
  );

  assign wr_bin_s   = PW'(afq_pkg::gray_to_bin(32'(wr_gray_s)));
  assign rd_fire    = rd_en & ~empty & ~busy;
  assign rd_bin_nxt = rd_bin + PW'(rd_fire);
  assign lvl_now    = wr_bin_s - rd_bin;
  assign lvl_nxt    = wr_bin_s - rd_bin_nxt;
  assign rd_addr    = rd_bin[AW-1:0];

  always_ff @(posedge clk) begin
    if (busy) begin
      rd_bin       <= '0;
      rd_gray      <= '0;
      dout         <= '0;
      empty        <= 1'b1;
      almost_empty <= 1'b0;
      prog_empty   <= 1'b1;
      valid        <= 1'b0;
      underflow    <= 1'b0;
      level        <= '0;
    end else begin
      rd_bin       <= rd_bin_nxt;
      rd_gray      <= PW'(afq_pkg::bin_to_gray(32'(rd_bin_nxt)));
      if (rd_fire) dout <= mem_q;
      empty        <= (lvl_nxt == '0);
      almost_empty <= (lvl_nxt == LVL_ONE);
      prog_empty   <= (lvl_nxt <= LVL_PE);
      valid        <= rd_fire;
      underflow    <= rd_en & empty;
      level        <= CW'(lvl_now >> (PW - CW));
    end
  end

  p_no_underflow_r3: assert property (@(posedge clk) disable iff (busy)
    (rd_en && empty) |=> (underflow && !valid && $stable(rd_bin)));

  p_valid_r4: assert property (@(posedge clk) disable iff (busy)
    (rd_en && !empty) |=> (valid && !underflow));

  p_empty_ae_excl_r6: assert property (@(posedge clk) disable iff (busy)
    !(empty && almost_empty));

  p_empty_pe_r8: assert property (@(posedge clk) disable iff (busy)
    empty |-> prog_empty);

  p_level_bound_r10: assert property (@(posedge clk) disable iff (busy)
    lvl_now <= LVL_FULL);

  p_gray_step_r12: assert property (@(posedge clk) disable iff (busy)
    $onehot0(rd_gray ^ $past(rd_gray)));
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 16,
  parameter int WR_CNT_W  = 5,
  parameter int RD_CNT_W  = 5,
  parameter int PFULL_SET = 12,
  parameter int PFULL_CLR = 8,
  parameter int PEMPTY_TH = 3
) (
  input  logic                rst,
  input  logic                wr_clk,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                wr_full,
  output logic                wr_almost_full,
  output logic                wr_prog_full,
  output logic                wr_ack,
  output logic                wr_overflow,
  output logic [WR_CNT_W-1:0] wr_level,
  output logic                wr_rst_busy,
  input  logic                rd_clk,
  input  logic                rd_en,
  output logic [DATA_W-1:0]   rd_data,
  output logic                rd_empty,
  output logic                rd_almost_empty,
  output logic                rd_prog_empty,
  output logic                rd_valid,
  output logic                rd_underflow,
  output logic [RD_CNT_W-1:0] rd_level,
  output logic                rd_rst_busy
);
  localparam int AW = $clog2(DEPTH);

  logic [AW:0]     wr_gray, rd_gray;
  logic [AW-1:0]   wr_addr, rd_addr;
  logic            wr_fire;
  logic [DATA_W-1:0] mem_q;

  afq_ram #(.DW(DATA_W), .AW(AW)) u_ram (
    .wclk  (wr_clk),
    .we    (wr_fire),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (mem_q)
  );

  afq_wr_ctl #(.AW(AW), .CW(WR_CNT_W), .PF_SET(PFULL_SET), .PF_CLR(PFULL_CLR)) u_wr (
    .clk         (wr_clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .rd_gray_x   (rd_gray),
    .wr_gray     (wr_gray),
    .wr_addr     (wr_addr),
    .wr_fire     (wr_fire),
    .full        (wr_full),
    .almost_full (wr_almost_full),
    .prog_full   (wr_prog_full),
    .ack         (wr_ack),
    .overflow    (wr_overflow),
    .level       (wr_level),
    .busy        (wr_rst_busy)
  );

  afq_rd_ctl #(.DW(DATA_W), .AW(AW), .CW(RD_CNT_W), .PE_TH(PEMPTY_TH)) u_rd (
    .clk          (rd_clk),
    .rst          (rst),
    .rd_en        (rd_en),
    .wr_gray_x    (wr_gray),
    .mem_q        (mem_q),
    .rd_gray      (rd_gray),
    .rd_addr      (rd_addr),
    .dout         (rd_data),
    .empty        (rd_empty),
    .almost_empty (rd_almost_empty),
    .prog_empty   (rd_prog_empty),
    .valid        (rd_valid),
    .underflow    (rd_underflow),
    .level        (rd_level),
    .busy         (rd_rst_busy)
  );
endmodule

// File: tb/dual_clock_fifo_tb.sv
`timescale 1ns/100ps
module dual_clock_fifo_tb;
  localparam int DW = 8, DEPTH = 8, WCW = 4, RCW = 2, PFS = 6, PFC = 3, PET = 2;

  logic rst, wclk, rclk, wr_en, rd_en;
  logic [DW-1:0] wr_data, rd_data;
  logic wr_full, wr_almost_full, wr_prog_full, wr_ack, wr_overflow, wr_rst_busy;
  logic rd_empty, rd_almost_empty, rd_prog_empty, rd_valid, rd_underflow, rd_rst_busy;
  logic [WCW-1:0] wr_level;
  logic [RCW-1:0] rd_level;

  dual_clock_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .WR_CNT_W(WCW), .RD_CNT_W(RCW),
                    .PFULL_SET(PFS), .PFULL_CLR(PFC), .PEMPTY_TH(PET)) u_dut (
    .rst(rst), .wr_clk(wclk), .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
    .wr_almost_full(wr_almost_full), .wr_prog_full(wr_prog_full), .wr_ack(wr_ack),
    .wr_overflow(wr_overflow), .wr_level(wr_level), .wr_rst_busy(wr_rst_busy),
    .rd_clk(rclk), .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty),
    .rd_almost_empty(rd_almost_empty), .rd_prog_empty(rd_prog_empty), .rd_valid(rd_valid),
    .rd_underflow(rd_underflow), .rd_level(rd_level), .rd_rst_busy(rd_rst_busy)
  );

  initial wclk = 1'b0;
  always #2 wclk = ~wclk;        // 250 MHz write clock
  initial rclk = 1'b0;
  always #3.5 rclk = ~rclk;      // unrelated read clock

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [DW-1:0] model[$];
  bit pf_model = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit pf_step(input bit cur, input int n);
    if (n >= PFS) return 1'b1;
    if (n < PFC) return 1'b0;
    return cur;
  endfunction

  // Write kernel: one attempt per write cycle with probability pct.
  task automatic wr_run(input int n, input int pct);
    bit pend_en = 0;
    bit pend_acc = 0;
    logic [DW-1:0] pend_d = '0;
    for (int i = 0; i <= n; i++) begin
      @(negedge wclk);
      if (pend_en) begin
        chk("R2", "wr_ack", int'(wr_ack), int'(pend_acc));
        chk("R1", "wr_overflow", int'(wr_overflow), int'(!pend_acc));
        if (pend_acc) model.push_back(pend_d);
      end
      if (i < n && ($urandom % 100) < pct) begin
        pend_en = 1; pend_d = DW'($urandom); pend_acc = !wr_full && !wr_rst_busy;
        wr_en = 1'b1; wr_data = pend_d;
      end else begin
        pend_en = 0; pend_acc = 0; wr_en = 1'b0;
      end
    end
  endtask

  // Read kernel: scoreboard on every accepted read (R12 crossing checked end to end).
  task automatic rd_run(input int n, input int pct);
    bit pend_en = 0;
    bit pend_acc = 0;
    logic [DW-1:0] exp_d;
    for (int i = 0; i <= n; i++) begin
      @(negedge rclk);
      if (pend_en) begin
        chk("R3", "rd_underflow", int'(rd_underflow), int'(!pend_acc));
        chk("R4", "rd_valid", int'(rd_valid), int'(pend_acc));
        if (pend_acc) begin
          if (model.size() == 0) chk("R4", "read with no word stored", 1, 0);
          else begin
            exp_d = model.pop_front();
            chk("R4 R12", "rd_data order", int'(rd_data), int'(exp_d));
          end
        end
      end
      if (i < n && ($urandom % 100) < pct) begin
        pend_en = 1; pend_acc = !rd_empty && !rd_rst_busy; rd_en = 1'b1;
      end else begin
        pend_en = 0; pend_acc = 0; rd_en = 1'b0;
      end
    end
  endtask

  task automatic settle();
    repeat (10) @(posedge rclk);
    @(negedge wclk);
  endtask

  task automatic check_state(input int n);
    chk("R9", "wr_level settled", int'(wr_level), n);
    chk("R10", "rd_level settled", int'(rd_level), n >> 2);
    chk("R5", "wr_full", int'(wr_full), int'(n == DEPTH));
    chk("R5", "wr_almost_full", int'(wr_almost_full), int'(n == DEPTH - 1));
    chk("R6", "rd_empty", int'(rd_empty), int'(n == 0));
    chk("R6", "rd_almost_empty", int'(rd_almost_empty), int'(n == 1));
    chk("R8", "rd_prog_empty", int'(rd_prog_empty), int'(n <= PET));
    chk("R7", "wr_prog_full", int'(wr_prog_full), int'(pf_model));
  endtask

  task automatic timed_write(input int n);
    logic [DW-1:0] v;
    v = DW'($urandom);
    @(negedge wclk); wr_en = 1'b1; wr_data = v;
    @(negedge wclk); wr_en = 1'b0;
    chk("R2", "wr_ack timed", int'(wr_ack), 1);
    chk("R9", "wr_level one edge after write", int'(wr_level), n);
    model.push_back(v);
    @(negedge wclk);
    chk("R9", "wr_level two edges after write", int'(wr_level), n + 1);
  endtask

  task automatic timed_read();
    logic [DW-1:0] e;
    @(negedge rclk); rd_en = 1'b1;
    @(negedge rclk); rd_en = 1'b0;
    e = model.pop_front();
    chk("R4", "rd_valid timed", int'(rd_valid), 1);
    chk("R4", "rd_data timed", int'(rd_data), int'(e));
    chk("R10", "rd_level one edge after read", int'(rd_level), 1);
    @(negedge rclk);
    chk("R10", "rd_level two edges after read", int'(rd_level), 0);
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog run actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    repeat (6) @(negedge wclk);
    chk("R11", "wr_rst_busy in reset", int'(wr_rst_busy), 1);
    chk("R11", "rd_rst_busy in reset", int'(rd_rst_busy), 1);
    rst = 1'b0;
    @(negedge wclk);
    chk("R11", "wr_rst_busy one edge after release", int'(wr_rst_busy), 1);
    wait (!wr_rst_busy && !rd_rst_busy);
    @(negedge wclk);
    chk("R11", "reset wr_level", int'(wr_level), 0);
    chk("R11", "reset wr_full", int'(wr_full), 0);
    chk("R11", "reset wr_ack", int'(wr_ack), 0);
    chk("R11", "reset rd_empty", int'(rd_empty), 1);
    chk("R11", "reset rd_prog_empty", int'(rd_prog_empty), 1);
    chk("R11", "reset rd_valid", int'(rd_valid), 0);
    chk("R11", "reset wr_prog_full", int'(wr_prog_full), 0);

    // Read on empty is refused
    rd_run(1, 100);
    settle();
    check_state(0);

    // Fill one word at a time
    for (int n = 1; n <= DEPTH; n++) begin
      if (n == 4) timed_write(3);
      else wr_run(1, 100);
      settle();
      pf_model = pf_step(pf_model, n);
      check_state(n);
    end

    // Write while full is refused, contents kept
    chk("R1", "wr_full before refused write", int'(wr_full), 1);
    wr_run(1, 100);
    settle();
    check_state(DEPTH);
    chk("R1", "model depth after refused write", model.size(), DEPTH);

    // Drain one word at a time through the hysteresis band
    for (int n = DEPTH - 1; n >= 0; n--) begin
      if (n == 3) timed_read();
      else rd_run(1, 100);
      settle();
      pf_model = pf_step(pf_model, n);
      check_state(n);
    end
    rd_run(2, 100);

    // Random concurrent traffic, balanced
    fork
      wr_run(3000, 60);
      rd_run(3000, 50);
    join
    settle();
    rd_run(2 * DEPTH + 4, 100);
    settle();
    pf_model = 1'b0;
    check_state(0);
    chk("R4", "all words returned", model.size(), 0);

    // Random traffic, fast writer and slow reader to reach full
    fork
      wr_run(2000, 85);
      rd_run(1200, 25);
    join
    settle();
    rd_run(2 * DEPTH + 4, 100);
    settle();
    check_state(0);
    chk("R4", "all words returned after full stress", model.size(), 0);

    // Reset with data stored
    wr_run(6, 100);
    settle();
    @(negedge wclk); rst = 1'b1;
    @(negedge wclk); wr_en = 1'b1; wr_data = 8'h5a;
    @(negedge wclk); wr_en = 1'b0;
    chk("R11", "no ack while busy", int'(wr_ack), 0);
    chk("R11", "wr_rst_busy mid reset", int'(wr_rst_busy), 1);
    repeat (4) @(negedge rclk);
    chk("R11", "rd_rst_busy mid reset", int'(rd_rst_busy), 1);
    rst = 1'b0;
    model.delete();
    pf_model = 1'b0;
    wait (!wr_rst_busy && !rd_rst_busy);
    settle();
    check_state(0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule